// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block drives an 8-bit successive-approximation converter. The converter has eight multiplexed analog inputs. A start pulse begins a conversion and, in that same cycle, captures the channel number and the conversion-clock divider setting. The sequencer first holds the sample switch closed for a fixed window. It then tests the result bits one at a time, from the most significant bit down. For each bit it drives a trial code to the external DAC and reads back a single comparator bit. The DAC, the sample switch and the comparator are all outside the block.

One conversion always takes 27 conversion-clock periods. The conversion clock is the system clock itself, or the system clock divided by two. When the last period ends, the result register loads, a sticky done flag sets, and a one-cycle interrupt pulse is raised. The done flag stays set until a clear request arrives.

The state machine has six states. Each transition below fires only on a conversion-clock tick, except the first.
- `ST_IDLE` goes to `ST_SAMPLE` on an accepted start. This transition does not wait for a tick.
- `ST_SAMPLE` goes to `ST_SETTLE` after 6 ticks.
- `ST_SETTLE` goes to `ST_TRIAL_SET` after 1 tick.
- `ST_TRIAL_SET` goes to `ST_TRIAL_DECIDE` after 1 tick.
- `ST_TRIAL_DECIDE` goes back to `ST_TRIAL_SET` after 1 tick while bits remain. After the last bit it goes to `ST_FINISH` instead.
- `ST_FINISH` goes to `ST_IDLE` after 4 ticks. The result loads on that transition.

Top module: `adc_sar_seq`

## Requirements
- R1: After reset, `busy`, `done`, `irq` and `sample_en` are 0, and `result` is 00h.
- R2: The result is straight binary. With a comparator that reports 1 when the input is at or above the DAC code, an input at integer level L gives code L, including the boundary codes 00h, 01h, FEh and FFh.
- R3: Bits are decided from the MSB down. The first non-zero trial code driven in a conversion is 80h.
- R4: `mux_sel` equals the channel number captured at the accepted start. The result is the conversion of that channel.
- R5: A conversion spans 27 conversion-clock periods, so `busy` is high for exactly 27×D system cycles after the start edge. D is 1 when `clk_div2` is 0 at start, and 2 when it is 1.
- R6: `sample_en` is high for the first 6 conversion-clock periods only, that is, 6×D system cycles.
- R7: A start request while `busy` is high is ignored. The frame length and the result are unchanged.
- R8: Changing `chan_sel` during a conversion does not alter `mux_sel` or the result.
- R9: `done` sets in the cycle `result` updates and stays set until `done_clr`. `irq` is high for exactly one cycle per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled each cycle |
| chan_sel | input | 3 | Channel to convert, captured at start |
| clk_div2 | input | 1 | 0: conversion clock = system clock; 1: half rate |
| done_clr | input | 1 | Clears the done flag |
| cmp_in | input | 1 | Comparator: 1 when input ≥ DAC code |
| mux_sel | output | 3 | Analog multiplexer select |
| sample_en | output | 1 | Sample switch enable |
| dac_code | output | 8 | Trial code to the DAC |
| result | output | 8 | Last conversion result |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `cmp_in` is a function of the DAC code and of the currently selected channel only, and that it is stable whenever the sequencer samples it in `ST_TRIAL_DECIDE`. The bench models an ideal comparator directly from `dac_code` and `mux_sel`. It holds each channel's analog level constant for the whole of a conversion. Start, `chan_sel` and `done_clr` change only at falling edges. Random levels, channels and divider settings are mixed with fixed boundary levels and with mid-conversion disturbances.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_SETTLE,
        ST_TRIAL_SET,
        ST_TRIAL_DECIDE,
        ST_FINISH
    } seq_state_t;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic div2,
    output logic tick
);
    logic phase;
    logic div2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase  <= 1'b0;
            div2_q <= 1'b0;
        end else if (restart) begin
            phase  <= 1'b0;
            div2_q <= div2;
        end else if (run) begin
            phase  <= ~phase;
        end
    end

    assign tick = run & (div2_q ? phase : 1'b1);

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div2_q && tick) |=> !tick);
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
    import adc_seq_pkg::*;
#(
    parameter int RES          = 8,
    parameter int NCH          = 8,
    parameter int SAMPLE_TICKS = 6,
    parameter int SETTLE_TICKS = 1,
    parameter int FRAME_TICKS  = 27,
    localparam int CHW         = $clog2(NCH),
    localparam int CW          = $clog2(FRAME_TICKS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [CHW-1:0] chan_sel,
    input  logic           tick,
    input  logic           cmp_in,
    output logic           accept,
    output logic           busy,
    output logic           sample_en,
    output logic [CHW-1:0] mux_sel,
    output logic [RES-1:0] dac_code,
    output logic [RES-1:0] acc,
    output logic           conv_end
);
    localparam int FINISH_TICKS = FRAME_TICKS - SAMPLE_TICKS - SETTLE_TICKS - 2 * RES;
    localparam logic [CW-1:0] SAMP_LAST = CW'(SAMPLE_TICKS - 1);
    localparam logic [CW-1:0] SETL_LAST = CW'(SETTLE_TICKS - 1);
    localparam logic [CW-1:0] FIN_LAST  = CW'(FINISH_TICKS - 1);

    seq_state_t     state, nxt;
    logic [CW-1:0]  cnt;
    logic [RES-1:0] mask;

    assign accept = start && (state == ST_IDLE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:         if (start) nxt = ST_SAMPLE;
            ST_SAMPLE:       if (tick && cnt == SAMP_LAST) nxt = ST_SETTLE;
            ST_SETTLE:       if (tick && cnt == SETL_LAST) nxt = ST_TRIAL_SET;
            ST_TRIAL_SET:    if (tick) nxt = ST_TRIAL_DECIDE;
            ST_TRIAL_DECIDE: if (tick) nxt = mask[0] ? ST_FINISH : ST_TRIAL_SET;
            ST_FINISH:       if (tick && cnt == FIN_LAST) nxt = ST_IDLE;
            default:         nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) cnt <= '0;
            else if (tick)    cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc     <= '0;
            mask    <= '0;
            mux_sel <= '0;
        end else if (accept) begin
            acc     <= '0;
            mask    <= {1'b1, {(RES-1){1'b0}}};
            mux_sel <= chan_sel;
        end else if (state == ST_TRIAL_DECIDE && tick) begin
            if (cmp_in) acc <= acc | mask;
            mask <= mask >> 1;
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        sample_en = (state == ST_SAMPLE);
        conv_end  = (state == ST_FINISH) && tick && (cnt == FIN_LAST);
        unique case (state)
            ST_TRIAL_SET, ST_TRIAL_DECIDE: dac_code = acc | mask;
            ST_FINISH:                     dac_code = acc;
            default:                       dac_code = '0;
        endcase
    end

    // R3
    mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask));
    // R8
    mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mux_sel));
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
    parameter int RES = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           conv_end,
    input  logic [RES-1:0] acc,
    input  logic           done_clr,
    output logic [RES-1:0] result,
    output logic           done,
    output logic           irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
            irq    <= 1'b0;
        end else begin
            irq <= conv_end;
            if (conv_end) begin
                result <= acc;
                done   <= 1'b1;
            end else if (done_clr) begin
                done   <= 1'b0;
            end
        end
    end

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R9
    result_on_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> irq);
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
    parameter int RES          = 8,
    parameter int NCH          = 8,
    parameter int SAMPLE_TICKS = 6,
    parameter int SETTLE_TICKS = 1,
    parameter int FRAME_TICKS  = 27,
    localparam int CHW         = $clog2(NCH),
    localparam int CW          = $clog2(FRAME_TICKS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [CHW-1:0] chan_sel,
    input  logic           clk_div2,
    input  logic           done_clr,
    input  logic           cmp_in,
    output logic [CHW-1:0] mux_sel,
    output logic           sample_en,
    output logic [RES-1:0] dac_code,
    output logic [RES-1:0] result,
    output logic           busy,
    output logic           done,
    output logic           irq
);
    logic           tick;
    logic           accept;
    logic           conv_end;
    logic [RES-1:0] acc;

    adc_tick_gen u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .restart(accept),
        .div2(clk_div2), .tick(tick)
    );

    adc_sar_core #(
        .RES(RES), .NCH(NCH), .SAMPLE_TICKS(SAMPLE_TICKS),
        .SETTLE_TICKS(SETTLE_TICKS), .FRAME_TICKS(FRAME_TICKS)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
        .tick(tick), .cmp_in(cmp_in), .accept(accept), .busy(busy),
        .sample_en(sample_en), .mux_sel(mux_sel), .dac_code(dac_code),
        .acc(acc), .conv_end(conv_end)
    );

    adc_result_reg #(.RES(RES)) u_res (
        .clk(clk), .rst_n(rst_n), .conv_end(conv_end), .acc(acc),
        .done_clr(done_clr), .result(result), .done(done), .irq(irq)
    );

    logic [CW-1:0] frame_ticks;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           frame_ticks <= '0;
        else if (accept)      frame_ticks <= '0;
        else if (busy & tick) frame_ticks <= frame_ticks + 1'b1;
    end

    // R5
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (frame_ticks == CW'(FRAME_TICKS)));
    // R9
    done_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> irq);
endmodule

// File: tb/tb_adc_sar_seq.sv
`timescale 1ns/1ps
module tb_adc_sar_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] chan_sel = '0;
    logic       clk_div2 = 1'b0;
    logic       done_clr = 1'b0;
    logic       cmp_in;
    logic [2:0] mux_sel;
    logic       sample_en;
    logic [7:0] dac_code;
    logic [7:0] result;
    logic       busy, done, irq;

    logic [7:0] level [8];
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    assign cmp_in = (level[mux_sel] >= dac_code);

    adc_sar_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
        .clk_div2(clk_div2), .done_clr(done_clr), .cmp_in(cmp_in),
        .mux_sel(mux_sel), .sample_en(sample_en), .dac_code(dac_code),
        .result(result), .busy(busy), .done(done), .irq(irq)
    );

    function automatic int ideal_code(input int lv);
        if (lv < 0)   return 0;
        if (lv > 255) return 255;
        return lv;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic convert(input int ch, input bit div, input bit disturb);
        int busy_cyc = 0, samp_cyc = 0, irq_cnt = 0, first_trial = -1;
        int d = div ? 2 : 1;
        int exp_code = ideal_code(level[ch]);
        @(negedge clk);
        chan_sel = ch[2:0]; clk_div2 = div; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) begin
            busy_cyc++;
            if (sample_en) samp_cyc++;
            if (irq) irq_cnt++;
            if (first_trial < 0 && dac_code != 0) first_trial = dac_code;
            if (busy_cyc == 1) check(mux_sel == ch[2:0], "R4 mux_sel", mux_sel, ch);
            if (disturb && busy_cyc == 9) begin
                start = 1'b1; chan_sel = ch[2:0] ^ 3'd5; clk_div2 = ~div;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (irq) irq_cnt++;
        check(done == 1'b1, "R9 done set at result update", done, 1);
        check(result == exp_code[7:0], disturb ? "R7/R8 result" : "R2/R4 result", result, exp_code);
        check(busy_cyc == 27 * d, disturb ? "R7 frame length" : "R5 frame length", busy_cyc, 27 * d);
        check(samp_cyc == 6 * d, "R6 sample window", samp_cyc, 6 * d);
        check(first_trial == 8'h80 || (first_trial < 0 && exp_code == 0),
              "R3 first trial", first_trial, 128);
        if (disturb) check(mux_sel == ch[2:0], "R8 mux_sel held", mux_sel, ch);
        repeat (3) begin
            @(negedge clk);
            if (irq) irq_cnt++;
        end
        check(irq_cnt == 1, "R9 irq pulse count", irq_cnt, 1);
        check(done == 1'b1, "R9 done sticky", done, 1);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        check(done == 1'b0, "R9 done cleared", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 8; i++) level[i] = 8'(i * 31);
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && irq == 0 && sample_en == 0, "R1 reset flags",
              {busy, done, irq, sample_en}, 0);
        check(result == 8'h00, "R1 reset result", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        level[0] = 8'h00; level[1] = 8'h01; level[6] = 8'hFE; level[7] = 8'hFF;
        convert(0, 1'b0, 1'b0);
        convert(1, 1'b1, 1'b0);
        convert(6, 1'b0, 1'b0);
        convert(7, 1'b1, 1'b0);
        convert(3, 1'b0, 1'b1);
        convert(5, 1'b1, 1'b1);
        for (int n = 0; n < 24; n++) begin
            for (int c = 0; c < 8; c++) level[c] = 8'($urandom_range(0, 255));
            convert(int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 3) == 0));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule